// File: doc/BRIEF.md
# Switch Activation Order Recorder

This block watches a bank of switch inputs that all start in the OFF position and logs the order in which they become ON. Each raw input first passes through a synchroniser and a stable-time filter. The filtered levels then go to an edge detector. When a rising edge arrives from a switch that has not been logged yet, the recorder appends one entry to an ordered log.

An entry holds a mask of every switch that rose in that clock cycle, the index of the lowest switch in the mask, a flag that is set when the mask holds more than one switch, and the entry's position number. Switches that rise together therefore share one entry and are neither lost nor split into a false order.

A host or a display steps through the log with a read index. A done flag goes high once every switch has been logged. The log clears itself when all filtered switches are back OFF, and it also clears on reset.

Top module: `swo_order_recorder`

## Requirements
- R1: After reset, `count` is 0, `done` is 0, and every read index returns an all-zero entry.
- R2: A raw input level that holds for fewer than `DEBOUNCE_CYCLES` consecutive cycles after synchronisation never creates an entry.
- R3: A single switch that turns ON and stays ON creates one entry. In that entry, `rd_mask` has only that switch's bit set (bit k for switch k), `rd_first` equals k, `rd_multi` is 0, and `rd_seq` is the entry's read index plus one.
- R4: Entries are stored in order of activation. Read index 0 returns the earliest entry, and `count` rises by one for each new entry.
- R5: Switches that reach the filtered ON level in the same cycle share one entry. Its `rd_mask` holds all of their bits, `rd_first` is the lowest index among them, and `rd_multi` is 1.
- R6: A switch that has already been logged creates no further entry if it goes OFF and then ON again. `count` and all entries stay unchanged.
- R7: A switch going OFF never creates an entry.
- R8: When every filtered switch is OFF and at least one switch has been logged, `count` and `done` return to 0 and all entries read as zero. Later activations are logged again from read index 0.
- R9: `done` is 1 exactly while every switch has been logged since the last restart.
- R10: A read index at or above `count` returns an all-zero entry.
- R11: From one cycle to the next, `count` stays the same, rises by one, or returns to 0. It never exceeds the number of switches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_raw | input | N_SW | Raw switch levels, 1 = ON, bit k = switch k |
| rd_idx | input | IW | Log entry to read, 0 = earliest |
| rd_mask | output | N_SW | Switches that rose together in the selected entry |
| rd_first | output | IW | Lowest switch index in the selected entry |
| rd_multi | output | 1 | Selected entry holds more than one switch |
| rd_seq | output | CW | Position number of the selected entry (index plus one), 0 if empty |
| count | output | CW | Number of valid entries |
| done | output | 1 | Every switch has been logged |

## Verification
The assertions assume that `rd_idx` and the raw switch levels change only away from the rising clock edge. They also assume that reset is held for several cycles at start-up, so that every history term they use has a defined value. The stimulus drives all inputs on the falling edge and holds reset for five cycles. Each stable switch level is kept well beyond the filter time before the outputs are compared. Deliberate glitches are kept shorter than the filter threshold, so the expected log can be derived from the stable levels alone.

// File: rtl/swo_pkg.sv
package swo_pkg;

    localparam int unsigned SW_LIMIT = 32;

    typedef logic [SW_LIMIT-1:0] sw_word_t;

    typedef enum logic [1:0] {
        REC_HOLD    = 2'd0,
        REC_APPEND  = 2'd1,
        REC_RESTART = 2'd2
    } rec_op_e;

    function automatic int unsigned lowest_set(input sw_word_t v);
        int unsigned r;
        r = 0;
        for (int i = SW_LIMIT - 1; i >= 0; i--) begin
            if (v[i]) r = i;
        end
        return r;
    endfunction

    function automatic logic several_set(input sw_word_t v);
        return (v & (v - 1)) != '0;
    endfunction

endpackage

// File: rtl/swo_sync_filter.sv
module swo_sync_filter #(
    parameter int unsigned N_SW            = 5,
    parameter int unsigned SYNC_STAGES     = 2,
    parameter int unsigned DEBOUNCE_CYCLES = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_SW-1:0] raw,
    output logic [N_SW-1:0] clean
);
    localparam int unsigned DBW = $clog2(DEBOUNCE_CYCLES + 1);

    for (genvar g = 0; g < N_SW; g++) begin : g_sw
        logic [SYNC_STAGES-1:0] shreg;
        logic [DBW-1:0]         stable_cnt;
        logic                   level;

        always_ff @(posedge clk) begin
            if (rst) shreg <= '0;
            else     shreg <= {shreg[SYNC_STAGES-2:0], raw[g]};
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                stable_cnt <= '0;
                level      <= 1'b0;
            end else if (shreg[SYNC_STAGES-1] == level) begin
                stable_cnt <= '0;
            end else if (stable_cnt == DBW'(DEBOUNCE_CYCLES - 1)) begin
                level      <= shreg[SYNC_STAGES-1];
                stable_cnt <= '0;
            end else begin
                stable_cnt <= stable_cnt + 1'b1;
            end
        end

        assign clean[g] = level;
    end

endmodule

// File: rtl/swo_event_detect.sv
module swo_event_detect #(
    parameter int unsigned N_SW = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            restart,
    input  logic [N_SW-1:0] clean,
    output logic [N_SW-1:0] new_ev,
    output logic [N_SW-1:0] logged
);
    logic [N_SW-1:0] prev;
    logic [N_SW-1:0] rise;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= clean;
    end

    assign rise   = (clean ^ prev) & clean;
    assign new_ev = rise & ~logged;

    always_ff @(posedge clk) begin
        if (rst || restart) logged <= '0;
        else                logged <= logged | new_ev;
    end

endmodule

// File: rtl/swo_record.sv
module swo_record
    import swo_pkg::*;
#(
    parameter int unsigned N_SW = 5,
    localparam int unsigned IW  = (N_SW > 1) ? $clog2(N_SW) : 1,
    localparam int unsigned CW  = $clog2(N_SW + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  rec_op_e         op,
    input  logic [N_SW-1:0] wr_mask,
    input  logic [IW-1:0]   rd_idx,
    output logic [N_SW-1:0] rd_mask,
    output logic [IW-1:0]   rd_first,
    output logic            rd_multi,
    output logic [CW-1:0]   rd_seq,
    output logic [CW-1:0]   count
);
    typedef struct packed {
        logic [CW-1:0]   seq;
        logic [N_SW-1:0] mask;
        logic [IW-1:0]   first;
        logic            multi;
    } entry_t;

    entry_t slot [N_SW];
    entry_t wr_entry;
    entry_t rd_entry;

    always_comb begin
        wr_entry.seq   = count + 1'b1;
        wr_entry.mask  = wr_mask;
        wr_entry.first = IW'(lowest_set(sw_word_t'(wr_mask)));
        wr_entry.multi = several_set(sw_word_t'(wr_mask));
    end

    for (genvar i = 0; i < N_SW; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || op == REC_RESTART)
                slot[i] <= '0;
            else if (op == REC_APPEND && count == CW'(i))
                slot[i] <= wr_entry;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || op == REC_RESTART) count <= '0;
        else if (op == REC_APPEND)    count <= count + 1'b1;
    end

    always_comb begin
        if (int'(rd_idx) < N_SW) rd_entry = slot[rd_idx];
        else                     rd_entry = '0;
    end

    assign rd_mask  = rd_entry.mask;
    assign rd_first = rd_entry.first;
    assign rd_multi = rd_entry.multi;
    assign rd_seq   = rd_entry.seq;

endmodule

// File: rtl/swo_order_recorder.sv
module swo_order_recorder
    import swo_pkg::*;
#(
    parameter int unsigned N_SW            = 5,
    parameter int unsigned SYNC_STAGES     = 2,
    parameter int unsigned DEBOUNCE_CYCLES = 8,
    localparam int unsigned IW = (N_SW > 1) ? $clog2(N_SW) : 1,
    localparam int unsigned CW = $clog2(N_SW + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_SW-1:0] sw_raw,
    input  logic [IW-1:0]   rd_idx,
    output logic [N_SW-1:0] rd_mask,
    output logic [IW-1:0]   rd_first,
    output logic            rd_multi,
    output logic [CW-1:0]   rd_seq,
    output logic [CW-1:0]   count,
    output logic            done
);
    logic [N_SW-1:0] clean;
    logic [N_SW-1:0] new_ev;
    logic [N_SW-1:0] logged;
    logic            restart;
    rec_op_e         op;

    swo_sync_filter #(
        .N_SW            (N_SW),
        .SYNC_STAGES     (SYNC_STAGES),
        .DEBOUNCE_CYCLES (DEBOUNCE_CYCLES)
    ) u_filter (
        .clk   (clk),
        .rst   (rst),
        .raw   (sw_raw),
        .clean (clean)
    );

    assign restart = (clean == '0) && (logged != '0);

    swo_event_detect #(.N_SW(N_SW)) u_detect (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .clean   (clean),
        .new_ev  (new_ev),
        .logged  (logged)
    );

    always_comb begin
        if (restart)            op = REC_RESTART;
        else if (new_ev != '0)  op = REC_APPEND;
        else                    op = REC_HOLD;
    end

    swo_record #(.N_SW(N_SW)) u_record (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .wr_mask  (new_ev),
        .rd_idx   (rd_idx),
        .rd_mask  (rd_mask),
        .rd_first (rd_first),
        .rd_multi (rd_multi),
        .rd_seq   (rd_seq),
        .count    (count)
    );

    assign done = (logged == {N_SW{1'b1}});

endmodule

// File: rtl/swo_order_recorder_chk.sv
module swo_order_recorder_chk #(
    parameter int unsigned N_SW = 5,
    localparam int unsigned IW  = (N_SW > 1) ? $clog2(N_SW) : 1,
    localparam int unsigned CW  = $clog2(N_SW + 1)
) (
    input logic            clk,
    input logic            rst,
    input logic [IW-1:0]   rd_idx,
    input logic [N_SW-1:0] rd_mask,
    input logic [IW-1:0]   rd_first,
    input logic            rd_multi,
    input logic [CW-1:0]   count,
    input logic            done
);
    a_r11_count_bounded: assert property (@(posedge clk) disable iff (rst)
        int'(count) <= N_SW);

    a_r11_count_step: assert property (@(posedge clk) disable iff (rst)
        (count == $past(count)) || (count == $past(count) + 1'b1) || (count == '0));

    a_r9_done_needs_entries: assert property (@(posedge clk) disable iff (rst)
        done |-> (count != '0));

    a_r8_done_drops_on_restart: assert property (@(posedge clk) disable iff (rst)
        $fell(done) |-> (count == '0));

    a_r10_empty_beyond_count: assert property (@(posedge clk) disable iff (rst)
        (rd_idx >= IW'(count) && int'(count) < N_SW) |-> (rd_mask == '0));

    a_r5_multi_matches_mask: assert property (@(posedge clk) disable iff (rst)
        (rd_mask != '0) |-> (rd_multi == ($countones(rd_mask) > 1)));

    a_r3_first_in_mask: assert property (@(posedge clk) disable iff (rst)
        (rd_mask != '0) |-> (((rd_mask >> rd_first) & 1) != 0));

endmodule

bind swo_order_recorder swo_order_recorder_chk #(.N_SW(N_SW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (rd_idx),
    .rd_mask  (rd_mask),
    .rd_first (rd_first),
    .rd_multi (rd_multi),
    .count    (count),
    .done     (done)
);

// File: tb/swo_order_recorder_test.sv
module swo_order_recorder_test;
    localparam int N  = 5;
    localparam int IW = 3;
    localparam int CW = 3;
    localparam int DB = 8;
    localparam int SETTLE = 40;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  sw_raw = '0;
    logic [IW-1:0] rd_idx = '0;
    logic [N-1:0]  rd_mask;
    logic [IW-1:0] rd_first;
    logic          rd_multi;
    logic [CW-1:0] rd_seq;
    logic [CW-1:0] count;
    logic          done;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    int unsigned exp_q[$];
    int unsigned exp_seen = 0;
    int unsigned prev_val = 0;
    int last_count = 0;

    always #2 clk = ~clk;

    swo_order_recorder #(.N_SW(N), .SYNC_STAGES(2), .DEBOUNCE_CYCLES(DB)) uut (
        .clk(clk), .rst(rst), .sw_raw(sw_raw), .rd_idx(rd_idx),
        .rd_mask(rd_mask), .rd_first(rd_first), .rd_multi(rd_multi),
        .rd_seq(rd_seq), .count(count), .done(done)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // R11: per-clock check of count against its previous value
    always @(negedge clk) begin
        if (!rst) begin
            chk("R11", "count bound", int'(count) <= N, 1);
            chk("R11", "count step",
                (int'(count) == last_count || int'(count) == last_count + 1 || count == 0), 1);
        end
        last_count = int'(count);
    end

    task automatic check_all(input string req);
        int lo;
        int unsigned m;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            rd_idx = IW'(i);
            #1;
            if (i < exp_q.size()) begin
                m = exp_q[i];
                lo = 0;
                for (int b = N - 1; b >= 0; b--) if (m[b]) lo = b;
                chk(req, $sformatf("mask[%0d]", i), int'(rd_mask), int'(m));
                chk(req, $sformatf("first[%0d]", i), int'(rd_first), lo);
                chk(req, $sformatf("multi[%0d]", i), int'(rd_multi), int'($countones(m) > 1));
                chk(req, $sformatf("seq[%0d]", i), int'(rd_seq), i + 1);
            end else begin
                chk(req == "R10" ? "R10" : req, $sformatf("empty[%0d] (R10)", i),
                    int'({rd_mask, rd_first, rd_multi, rd_seq}), 0);
            end
        end
        chk(req, "count", int'(count), exp_q.size());
        chk(req, "done (R9)", int'(done), int'(exp_seen == (1 << N) - 1));
    endtask

    task automatic apply(input int unsigned val, input string req);
        int unsigned fresh;
        @(negedge clk);
        sw_raw = N'(val);
        repeat (SETTLE) @(negedge clk);
        fresh = val & ~prev_val & ~exp_seen;
        if (fresh != 0) begin
            exp_q.push_back(fresh);
            exp_seen |= fresh;
        end
        if (val == 0 && exp_seen != 0) begin
            exp_q.delete();
            exp_seen = 0;
        end
        prev_val = val;
        check_all(req);
    endtask

    task automatic glitch(input int unsigned bits, input string req);
        @(negedge clk);
        sw_raw = sw_raw ^ N'(bits);
        repeat (DB - 5) @(negedge clk);
        sw_raw = sw_raw ^ N'(bits);
        repeat (SETTLE) @(negedge clk);
        check_all(req);
    endtask

    initial begin
        #800000;
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        check_all("R1");
        glitch(5'b00010, "R2");
        apply(5'b10000, "R3");
        apply(5'b11000, "R4");
        glitch(5'b00100, "R2");
        apply(5'b11011, "R5");
        apply(5'b11010, "R7");
        apply(5'b11011, "R6");
        apply(5'b11111, "R9");
        apply(5'b00000, "R8");
        apply(5'b00100, "R8");
        apply(5'b00101, "R4");
        apply(5'b00000, "R8");
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule